// File: doc/BRIEF.md
# UART Modem Control and Loopback

This block keeps the modem control byte of a single UART channel and turns it into the channel's modem-side pins. A byte-wide port writes and reads the control byte. The three upper bits take a write only while an enhanced-feature enable input is high. The low bits set the active-low request-to-send and data-terminal-ready pins and an active-low general output pin. The same low bits enable the interrupt output driver. A hardware flow-control input can take over the request-to-send pin when auto-RTS is on.

Internal loopback is set by control bit 4. In loopback the transmit serial stream is turned back into the receive path, and the external transmit, RTS, DTR and general output pins rest at their inactive high level. The four upper modem status bits then show fixed control bits and no longer follow the external pins. Outside loopback, those status bits show the inverted external carrier-detect, ring, data-set-ready and clear-to-send pins.

Control bit 7 picks the baud clock prescale. The prescaler emits a one-cycle clock enable. It is high on every cycle in divide-by-1, and once every four cycles in divide-by-4.

Top module: `uart_modem_ctl`

## Requirements
- R1: A synchronous reset clears the control byte to 0x00. After reset, rd_data reads 0x00, rts_n, dtr_n and op_n are 1, irq_oe is 0, and baud_ce is 1 on every cycle.
- R2: On a cycle with wr_en high, bits 4..0 always take wr_data[4:0]. Bits 7..5 take wr_data[7:5] only if enh_wen is high on that cycle; otherwise they keep their previous value.
- R3: rd_data always returns the stored control byte, starting in the cycle after the write edge.
- R4: Outside loopback with auto-RTS off, rts_n is the inverse of bit 1 and dtr_n is the inverse of bit 0. A bit value of 1 drives the pin low.
- R5: Outside loopback with auto_rts_en high, rts_n is the inverse of flow_rts, and bit 1 has no effect on the pin.
- R6: irq_oe equals bit 3. Outside loopback, op_n is the inverse of bit 3.
- R7: trig_access equals bit 6, xon_any_en equals bit 5 and fifo_rdy_en equals bit 2.
- R8: With bit 4 clear, status_hi[3:0] equals the inverse of {cd_n, ri_n, dsr_n, cts_n}, rx_serial follows rx_pin, and tx_pin follows tx_serial.
- R9: With bit 4 set, status_hi[3:0] equals {bit3, bit2, bit0, bit1}, and the external status pins are ignored. rx_serial follows tx_serial, and rx_pin is ignored. tx_pin, rts_n, dtr_n and op_n are all 1.
- R10: With bit 7 clear, baud_ce is 1 on every cycle. With bit 7 set, baud_ce is a one-cycle pulse with a period of 4 cycles. Whenever bit 7 changes, the count restarts. Counting the first cycle with the new bit 7 value as cycle 0, pulses come at cycles 3, 7, 11 and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write data |
| enh_wen | input | 1 | Write enable for control bits 7..5 |
| rd_data | output | 8 | Control byte readback |
| auto_rts_en | input | 1 | Hardware flow control owns the RTS pin |
| flow_rts | input | 1 | Flow-control RTS request, 1 = assert |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| cd_n | input | 1 | Carrier detect pin, active low |
| tx_serial | input | 1 | Serial data from the transmitter |
| rx_pin | input | 1 | External receive pin |
| tx_pin | output | 1 | External transmit pin |
| rx_serial | output | 1 | Serial data to the receiver |
| status_hi | output | 4 | Modem status bits 7..4 |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| op_n | output | 1 | General output pin, active low |
| irq_oe | output | 1 | Interrupt output driver enable |
| trig_access | output | 1 | Selects the trigger control and level registers |
| xon_any_en | output | 1 | Any-character resume enable |
| fifo_rdy_en | output | 1 | FIFO ready register enable |
| baud_ce | output | 1 | Baud clock enable from the prescaler |

## Verification
The bench tries writes to the upper bits with enh_wen low. A design that ignored the guard would let bits 7..5 change, and a design that blocked the whole byte would freeze bits 4..0. In loopback it drives the external status and receive pins at random. A wrong crossing map would swap the DTR and RTS status bits, and a leaky mux would let the external pins through. It switches bit 7 back and forth with gaps of varied length. A prescaler that did not restart its count on a switch would give the first divided pulse too early or at a varying cycle.

// File: rtl/modem_ctl_pkg.sv
package modem_ctl_pkg;

  // Field layout matches the bit positions that the neighbouring logic decodes.
  typedef struct packed {
    logic div4;
    logic trig_acc;
    logic xon_any;
    logic loop_en;
    logic irq_en;
    logic rdy_en;
    logic rts_on;
    logic dtr_on;
  } mctl_t;

  localparam int CTL_W     = 8;
  localparam int GUARD_LSB = 5;
  localparam int STAT_W    = 4;

  // Control bit that feeds each status bit (index 0 = status bit 4) in loopback
  function automatic int loop_src(input int idx);
    case (idx)
      0:       return 1;
      1:       return 0;
      2:       return 2;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/mctl_store.sv
module mctl_store #(
  parameter int DW        = 8,
  parameter int GUARD_LSB = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          enh_wen,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (wr_en) begin
      if (enh_wen)
        q <= wr_data;
      else
        q <= {q[DW-1:GUARD_LSB], wr_data[GUARD_LSB-1:0]};
    end
  end

  // R2: the guarded field holds its value when its enable is low
  a_r2_upper_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !enh_wen) |=> (q[DW-1:GUARD_LSB] == $past(q[DW-1:GUARD_LSB])));

  // R2: the low field always takes the write
  a_r2_lower_follow: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (q[GUARD_LSB-1:0] == $past(wr_data[GUARD_LSB-1:0])));

  // R2: with the enable high, the whole byte takes the write
  a_r2_full_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && enh_wen) |=> (q == $past(wr_data)));

endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic div_sel,
  output logic ce
);

  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic          sel_q;
  logic          switched;

  assign switched = (div_sel != sel_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sel_q <= 1'b0;
    end else begin
      sel_q <= div_sel;
      if (switched)
        cnt <= CW'(1);
      else if (cnt == TOP)
        cnt <= '0;
      else
        cnt <= cnt + CW'(1);
    end
  end

  assign ce = div_sel ? (!switched && (cnt == TOP)) : 1'b1;

  // R10: divided enable is never two cycles wide
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (div_sel && ce) |=> (!ce || !div_sel));

  // R10: no enable in the first cycle after entering divide mode
  a_r10_restart: assert property (@(posedge clk) disable iff (rst)
    $rose(div_sel) |-> !ce);

  // R10: undivided mode enables every cycle
  a_r10_pass: assert property (@(posedge clk) disable iff (rst)
    !div_sel |-> ce);

endmodule

// File: rtl/modem_route.sv
module modem_route
  import modem_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  mctl_t             ctl,
  input  logic              auto_rts_en,
  input  logic              flow_rts,
  input  logic [STAT_W-1:0] pins_n,
  input  logic              tx_serial,
  input  logic              rx_pin,
  output logic              tx_pin,
  output logic              rx_serial,
  output logic [STAT_W-1:0] status_hi,
  output logic              rts_n,
  output logic              dtr_n,
  output logic              op_n
);

  logic       loop;
  logic [3:0] ctl_lo;

  assign loop   = ctl.loop_en;
  assign ctl_lo = {ctl.irq_en, ctl.rdy_en, ctl.rts_on, ctl.dtr_on};

  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    assign status_hi[i] = loop ? ctl_lo[loop_src(i)] : ~pins_n[i];
  end

  assign rx_serial = loop ? tx_serial : rx_pin;
  assign tx_pin    = loop ? 1'b1 : tx_serial;
  assign rts_n     = loop ? 1'b1 : ~(auto_rts_en ? flow_rts : ctl.rts_on);
  assign dtr_n     = loop ? 1'b1 : ~ctl.dtr_on;
  assign op_n      = loop ? 1'b1 : ~ctl.irq_en;

  // R9: crossing map of control bits into status bits
  a_r9_loop_map: assert property (@(posedge clk) disable iff (rst)
    loop |-> (status_hi == {ctl.irq_en, ctl.rdy_en, ctl.dtr_on, ctl.rts_on}));

  // R9: external outputs idle high in loopback
  a_r9_pins_idle: assert property (@(posedge clk) disable iff (rst)
    loop |-> (tx_pin && rts_n && dtr_n && op_n));

  // R8: receive path follows the pin outside loopback
  a_r8_rx_pass: assert property (@(posedge clk) disable iff (rst)
    !loop |-> (rx_serial == rx_pin));

  // R5: flow control owns RTS when enabled
  a_r5_auto_rts: assert property (@(posedge clk) disable iff (rst)
    (!loop && auto_rts_en) |-> (rts_n == !flow_rts));

endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import modem_ctl_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        enh_wen,
  output logic [7:0]  rd_data,
  input  logic        auto_rts_en,
  input  logic        flow_rts,
  input  logic        cts_n,
  input  logic        dsr_n,
  input  logic        ri_n,
  input  logic        cd_n,
  input  logic        tx_serial,
  input  logic        rx_pin,
  output logic        tx_pin,
  output logic        rx_serial,
  output logic [3:0]  status_hi,
  output logic        rts_n,
  output logic        dtr_n,
  output logic        op_n,
  output logic        irq_oe,
  output logic        trig_access,
  output logic        xon_any_en,
  output logic        fifo_rdy_en,
  output logic        baud_ce
);

  logic [CTL_W-1:0] ctl_q;
  mctl_t            ctl;

  mctl_store #(.DW(CTL_W), .GUARD_LSB(GUARD_LSB)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .enh_wen (enh_wen),
    .q       (ctl_q)
  );

  assign ctl = mctl_t'(ctl_q);

  modem_route u_route (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .auto_rts_en (auto_rts_en),
    .flow_rts    (flow_rts),
    .pins_n      ({cd_n, ri_n, dsr_n, cts_n}),
    .tx_serial   (tx_serial),
    .rx_pin      (rx_pin),
    .tx_pin      (tx_pin),
    .rx_serial   (rx_serial),
    .status_hi   (status_hi),
    .rts_n       (rts_n),
    .dtr_n       (dtr_n),
    .op_n        (op_n)
  );

  baud_prescale #(.DIV(PRESCALE)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .div_sel (ctl.div4),
    .ce      (baud_ce)
  );

  assign rd_data     = ctl_q;
  assign irq_oe      = ctl.irq_en;
  assign trig_access = ctl.trig_acc;
  assign xon_any_en  = ctl.xon_any;
  assign fifo_rdy_en = ctl.rdy_en;

  // R1: the first cycle out of reset reads a cleared byte
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd_data == 8'h00));

  // R6: interrupt driver enable and OP pin agree outside loopback
  a_r6_op_irq: assert property (@(posedge clk) disable iff (rst)
    !ctl.loop_en |-> (op_n == !irq_oe));

endmodule

// File: tb/uart_modem_ctl_bench.sv
`timescale 1ns/100ps
module uart_modem_ctl_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       enh_wen = 1'b0;
  logic       auto_rts_en = 1'b0;
  logic       flow_rts = 1'b0;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
  logic       tx_serial = 1'b1, rx_pin = 1'b1;
  logic [7:0] rd_data;
  logic [3:0] status_hi;
  logic       tx_pin, rx_serial, rts_n, dtr_n, op_n, irq_oe;
  logic       trig_access, xon_any_en, fifo_rdy_en, baud_ce;

  int checks = 0;
  int errors = 0;
  bit armed  = 0;
  bit done   = 0;

  // reference state
  logic [7:0] m_ctl = 8'h00;
  int         m_age = 0;

  always #2.5 clk = ~clk;

  uart_modem_ctl u_uart_modem_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .enh_wen(enh_wen),
    .rd_data(rd_data), .auto_rts_en(auto_rts_en), .flow_rts(flow_rts),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .cd_n(cd_n),
    .tx_serial(tx_serial), .rx_pin(rx_pin), .tx_pin(tx_pin), .rx_serial(rx_serial),
    .status_hi(status_hi), .rts_n(rts_n), .dtr_n(dtr_n), .op_n(op_n),
    .irq_oe(irq_oe), .trig_access(trig_access), .xon_any_en(xon_any_en),
    .fifo_rdy_en(fifo_rdy_en), .baud_ce(baud_ce)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model update
  always @(posedge clk) begin
    logic [7:0] nxt;
    if (rst) begin
      m_ctl = 8'h00;
      m_age = 0;
    end else begin
      nxt = m_ctl;
      if (wr_en) begin
        nxt[4:0] = wr_data[4:0];
        if (enh_wen) nxt[7:5] = wr_data[7:5];
      end
      if (nxt[7] != m_ctl[7]) m_age = 0;
      else m_age = m_age + 1;
      m_ctl = nxt;
    end
    armed = 1;
  end

  // per-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    bit loop;
    #1.5;
    if (armed && !done) begin
      loop = m_ctl[4];
      chk("R2 R3 readback", rd_data, m_ctl);
      chk(loop ? "R9 rts" : (auto_rts_en ? "R5 rts" : "R4 rts"), 8'(rts_n),
          8'(loop ? 1'b1 : (auto_rts_en ? !flow_rts : !m_ctl[1])));
      chk(loop ? "R9 dtr" : "R4 dtr", 8'(dtr_n), 8'(loop ? 1'b1 : !m_ctl[0]));
      chk(loop ? "R9 op" : "R6 op", 8'(op_n), 8'(loop ? 1'b1 : !m_ctl[3]));
      chk("R6 irq_oe", 8'(irq_oe), 8'(m_ctl[3]));
      chk("R7 enables", {5'd0, trig_access, xon_any_en, fifo_rdy_en},
          {5'd0, m_ctl[6], m_ctl[5], m_ctl[2]});
      chk(loop ? "R9 tx_pin" : "R8 tx_pin", 8'(tx_pin), 8'(loop ? 1'b1 : tx_serial));
      chk(loop ? "R9 rx_serial" : "R8 rx_serial", 8'(rx_serial), 8'(loop ? tx_serial : rx_pin));
      chk(loop ? "R9 status" : "R8 status", 8'(status_hi),
          loop ? {4'd0, m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]}
               : {4'd0, ~cd_n, ~ri_n, ~dsr_n, ~cts_n});
      chk("R10 baud_ce", 8'(baud_ce), 8'(m_ctl[7] ? ((m_age % 4) == 3) : 1'b1));
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d, input logic en);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; enh_wen = en;
    @(negedge clk);
    wr_en = 1'b0; enh_wen = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk); #1.5;
    // R1: reset state
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 pins", {5'd0, rts_n, dtr_n, op_n}, 8'h07);
    chk("R1 irq_oe", 8'(irq_oe), 8'h00);
    chk("R1 baud_ce", 8'(baud_ce), 8'h01);

    // R2: guarded upper bits
    wr(8'hFF, 1'b0); #1.5; chk("R2 guard low", rd_data, 8'h1F);
    wr(8'hE0, 1'b1); #1.5; chk("R2 guard high", rd_data, 8'hE0);
    wr(8'h0B, 1'b0); #1.5; chk("R2 upper kept", rd_data, 8'hEB);

    // R4/R5: RTS ownership
    wr(8'h03, 1'b1);
    auto_rts_en = 1'b1; flow_rts = 1'b0; idle(2);
    flow_rts = 1'b1; idle(2);
    auto_rts_en = 1'b0; idle(2);

    // R9: loopback with external pins wiggling
    wr(8'h1D, 1'b0);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      {cd_n, ri_n, dsr_n, cts_n} = 4'(k);
      tx_serial = k[0]; rx_pin = ~k[1];
    end
    wr(8'h12, 1'b0); idle(3);

    // R10: prescaler switching with varied gaps
    wr(8'h80, 1'b1); idle(20);
    wr(8'h00, 1'b1); idle(3);
    wr(8'h80, 1'b1); idle(6);
    wr(8'h90, 1'b1); idle(9);
    wr(8'h00, 1'b1); idle(2);

    // mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      wr_en       = ($urandom % 8) == 0;
      wr_data     = 8'($urandom);
      enh_wen     = 1'($urandom);
      auto_rts_en = 1'($urandom);
      flow_rts    = 1'($urandom);
      {cd_n, ri_n, dsr_n, cts_n} = 4'($urandom);
      tx_serial   = 1'($urandom);
      rx_pin      = 1'($urandom);
    end
    @(negedge clk);
    wr_en = 1'b0;
    idle(2);
    #2;
    finish_run();
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

endmodule